// File: doc/BRIEF.md
# Playback command port for a four-channel voice engine

This block is the host-facing command port of a four-channel sample playback engine. A processor writes bytes over an 8-bit bidirectional bus under an active-low chip select and write strobe. The port turns them into per-channel start and stop requests. A start takes two writes. The first byte has bit 7 set and carries the low seven bits of a 9-bit phrase number. The second byte carries the two high phrase bits, the target channel and a 4-bit gain code. A single byte with bit 7 clear is a suspend, and its mask can stop several channels at once.

The host strobes are sampled in the block's clock domain, so a write acts a fixed number of clocks after the strobe rises. For each channel the port keeps a busy flag. The flag rises a fixed delay after a start is issued, which models the engine's start-up latency. It drops on a stop or when the engine reports the end of playback. The host reads the four flags by pulling chip select and read strobe low together. The engine, the sample memory and the audio path are outside this block.

Top module: `voice_cmd_port`

## Requirements
- R1: While reset is low and after it ends, `play_start` and `play_stop` are 0, every busy flag reads 0, and the next accepted byte is taken as a first byte.
- R2: A byte is accepted only on a rising edge of `host_wr_n` while `host_cs_n` is low. A write strobe pulsed with chip select high changes no output and no busy flag.
- R3: A first byte with bit 7 = 1 followed by a second byte issues a one-cycle pulse on `play_start`. The pulse is one-hot, with channel field bits 5:4 of the second byte (00 selects bit 0, 11 selects bit 3). In the same cycle `play_phrase` = {second[7:6], first[6:0]} and `play_gain` = second[3:0].
- R4: A first byte on its own produces no `play_start` pulse.
- R5: A start whose 9-bit phrase number is zero produces no pulse, and the port then waits for a new first byte.
- R6: A byte with bit 7 = 0, accepted while no start is pending, gives a one-cycle pulse on `play_stop` equal to its bits 6:3 (bit 3 to channel bit 0, bit 6 to channel bit 3). Each selected busy flag reads 0 from the second clock after the pulse, and unselected flags are unchanged.
- R7: While a start is pending, the next accepted byte is always its second byte, whatever the value of bit 7.
- R8: With `host_cs_n` and `host_rd_n` both low, the block drives `host_bus[3:0]` with the busy flags (bit 0 is channel bit 0, 1 means playing) and `host_bus[7:4]` with 0.
- R9: A channel's busy flag reads 1 starting 35 clocks after the cycle in which its `play_start` pulse is visible, and reads 0 one clock earlier (`BUSY_DLY`).
- R10: A stop cancels a pending busy delay. When a stop reaches a channel in the same cycle that its delay expires, the flag stays 0.
- R11: A `play_done` bit held for one cycle clears that channel's busy flag at the next clock.
- R12: A start on a channel that is already busy leaves its flag at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_cs_n | input | 1 | Host chip select, active low |
| host_wr_n | input | 1 | Host write strobe, active low; data is taken on its rising edge |
| host_rd_n | input | 1 | Host read strobe, active low |
| host_bus | inout | 8 | Host data bus: command bytes in, busy flags out; released when not read |
| play_start | output | 4 | One-cycle, one-hot start request per channel |
| play_phrase | output | 9 | Phrase number that goes with `play_start` |
| play_gain | output | 4 | Attenuation code that goes with `play_start` |
| play_stop | output | 4 | One-cycle stop request mask per channel |
| play_done | input | 4 | Per-channel end-of-playback report from the engine |

## Verification
Two functions can act on a channel in the same clock: the busy delay expiring after a start, and a stop from a suspend byte. The bench places the suspend write so that its stop reaches the channel on exactly the expiry edge. It then reads the flags over the bus and expects that channel to read 0 while another busy channel keeps its 1. A separate test times the expiry on its own, reading 0 one clock before it and 1 on it, so that a shifted delay cannot hide the clash.

// File: rtl/voice_cmd_pkg.sv
package voice_cmd_pkg;
  localparam int CH_N     = 4;
  localparam int BUS_W    = 8;
  localparam int PHRASE_W = 9;
  localparam int GAIN_W   = 4;
  localparam int LOW_W    = 7;

  typedef enum logic {ST_FIRST, ST_SECOND} dec_state_t;

  typedef struct packed {
    logic [PHRASE_W-1:0] phrase;
    logic [GAIN_W-1:0]   gain;
  } play_args_t;
endpackage

// File: rtl/vc_rst_sync.sv
module vc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic q1, q2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q1 <= 1'b0;
      q2 <= 1'b0;
    end else begin
      q1 <= 1'b1;
      q2 <= q1;
    end
  end

  assign rst_sync_n = q2;
endmodule

// File: rtl/vc_strobe_capture.sv
module vc_strobe_capture
  import voice_cmd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             cs_n,
  input  logic             wr_n,
  input  logic [BUS_W-1:0] bus_in,
  output logic             wr_evt,
  output logic [BUS_W-1:0] wr_byte
);
  logic             s1_wr, s2_wr, s1_cs, s2_cs;
  logic [BUS_W-1:0] s1_dat, s2_dat;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_wr  <= 1'b1;
      s2_wr  <= 1'b1;
      s1_cs  <= 1'b1;
      s2_cs  <= 1'b1;
      s1_dat <= '0;
      s2_dat <= '0;
    end else begin
      s1_wr  <= wr_n;
      s2_wr  <= s1_wr;
      s1_cs  <= cs_n;
      s2_cs  <= s1_cs;
      s1_dat <= bus_in;
      s2_dat <= s1_dat;
    end
  end

  // rising write strobe, chip select sampled while the strobe was low
  assign wr_evt  = s1_wr & ~s2_wr & ~s2_cs;
  assign wr_byte = s2_dat;

  // R2: an accepted write is a single-cycle event
  p_single_wr_evt_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    wr_evt |=> !wr_evt);
endmodule

// File: rtl/vc_cmd_decode.sv
module vc_cmd_decode
  import voice_cmd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             wr_evt,
  input  logic [BUS_W-1:0] wr_byte,
  output logic [CH_N-1:0]  start_mask,
  output play_args_t       start_args,
  output logic [CH_N-1:0]  stop_mask
);
  localparam int SEL_W = $clog2(CH_N);

  dec_state_t          state_q, state_d;
  logic [LOW_W-1:0]    low_q, low_d;
  logic [CH_N-1:0]     start_q, start_d, stop_q, stop_d;
  play_args_t          args_q, args_d;
  logic [PHRASE_W-1:0] phrase_full;
  logic [SEL_W-1:0]    chan_sel;

  assign phrase_full = {wr_byte[BUS_W-1 -: 2], low_q};
  assign chan_sel    = wr_byte[5:4];

  always_comb begin
    state_d = state_q;
    low_d   = low_q;
    start_d = '0;
    stop_d  = '0;
    args_d  = args_q;
    if (wr_evt) begin
      unique case (state_q)
        ST_FIRST: begin
          if (wr_byte[BUS_W-1]) begin
            low_d   = wr_byte[LOW_W-1:0];
            state_d = ST_SECOND;
          end else begin
            stop_d  = wr_byte[6:3];
          end
        end
        ST_SECOND: begin
          state_d = ST_FIRST;
          if (phrase_full != '0) begin
            start_d       = CH_N'(1) << chan_sel;
            args_d.phrase = phrase_full;
            args_d.gain   = wr_byte[GAIN_W-1:0];
          end
        end
        default: state_d = ST_FIRST;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_FIRST;
      low_q   <= '0;
      start_q <= '0;
      stop_q  <= '0;
      args_q  <= '0;
    end else begin
      state_q <= state_d;
      start_q <= start_d;
      stop_q  <= stop_d;
      if (wr_evt) begin
        low_q  <= low_d;
        args_q <= args_d;
      end
    end
  end

  assign start_mask = start_q;
  assign start_args = args_q;
  assign stop_mask  = stop_q;

  p_start_onehot_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    $onehot0(start_q));
  p_start_pulse_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    (start_q != '0) |=> (start_q == '0));
  p_phrase_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_ni)
    (start_q != '0) |-> (args_q.phrase != '0));
  p_start_stop_excl_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    !((start_q != '0) && (stop_q != '0)));
endmodule

// File: rtl/vc_chan_track.sv
module vc_chan_track #(
  parameter int BUSY_DLY = 35
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic start,
  input  logic stop,
  input  logic done,
  output logic busy
);
  localparam int CW   = $clog2(BUSY_DLY + 1);
  localparam int LOAD = BUSY_DLY - 1;

  logic          busy_q, busy_d, pend_q, pend_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    busy_d = busy_q;
    pend_d = pend_q;
    cnt_d  = cnt_q;
    if (pend_q) begin
      if (cnt_q == CW'(1)) begin
        busy_d = 1'b1;
        pend_d = 1'b0;
      end else begin
        cnt_d = cnt_q - CW'(1);
      end
    end
    if (stop || done) begin
      busy_d = 1'b0;
      pend_d = 1'b0;
    end
    if (start) begin
      pend_d = 1'b1;
      cnt_d  = CW'(LOAD);
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      pend_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      pend_q <= pend_d;
      cnt_q  <= cnt_d;
    end
  end

  assign busy = busy_q;

  p_stop_clear_r10: assert property (@(posedge clk) disable iff (!rst_ni)
    stop |=> !busy);
  p_done_clear_r11: assert property (@(posedge clk) disable iff (!rst_ni)
    done |=> !busy);
  p_rise_clean_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(busy) |-> (!$past(stop) && !$past(done) && $past(pend_q)));
  p_restart_hold_r12: assert property (@(posedge clk) disable iff (!rst_ni)
    (start && busy && !stop && !done) |=> busy);
endmodule

// File: rtl/voice_cmd_port.sv
module voice_cmd_port
  import voice_cmd_pkg::*;
#(
  parameter int BUSY_DLY = 35
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                host_cs_n,
  input  logic                host_wr_n,
  input  logic                host_rd_n,
  inout  wire  [BUS_W-1:0]    host_bus,
  output logic [CH_N-1:0]     play_start,
  output logic [PHRASE_W-1:0] play_phrase,
  output logic [GAIN_W-1:0]   play_gain,
  output logic [CH_N-1:0]     play_stop,
  input  logic [CH_N-1:0]     play_done
);
  logic             rst_ni;
  logic             wr_evt;
  logic [BUS_W-1:0] wr_byte;
  logic [CH_N-1:0]  start_mask, stop_mask, busy;
  play_args_t       start_args;
  logic             rd_oe;

  vc_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_ni)
  );

  vc_strobe_capture u_cap (
    .clk     (clk),
    .rst_ni  (rst_ni),
    .cs_n    (host_cs_n),
    .wr_n    (host_wr_n),
    .bus_in  (host_bus),
    .wr_evt  (wr_evt),
    .wr_byte (wr_byte)
  );

  vc_cmd_decode u_dec (
    .clk        (clk),
    .rst_ni     (rst_ni),
    .wr_evt     (wr_evt),
    .wr_byte    (wr_byte),
    .start_mask (start_mask),
    .start_args (start_args),
    .stop_mask  (stop_mask)
  );

  for (genvar c = 0; c < CH_N; c++) begin : g_chan
    vc_chan_track #(.BUSY_DLY(BUSY_DLY)) u_trk (
      .clk    (clk),
      .rst_ni (rst_ni),
      .start  (start_mask[c]),
      .stop   (stop_mask[c]),
      .done   (play_done[c]),
      .busy   (busy[c])
    );
  end

  assign rd_oe    = ~host_cs_n & ~host_rd_n;
  assign host_bus = rd_oe ? {{(BUS_W-CH_N){1'b0}}, busy} : {BUS_W{1'bz}};

  assign play_start  = start_mask;
  assign play_phrase = start_args.phrase;
  assign play_gain   = start_args.gain;
  assign play_stop   = stop_mask;
endmodule

// File: tb/voice_cmd_port_tb_top.sv
`timescale 1ns/1ps
module voice_cmd_port_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cs_n, wr_n, rd_n;
  logic       drv_en;
  logic [7:0] drv_val;
  wire  [7:0] host_bus;
  logic [3:0] play_start, play_stop, play_gain, play_done;
  logic [8:0] play_phrase;

  int n_total = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  assign host_bus = drv_en ? drv_val : 8'hzz;

  voice_cmd_port dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_cs_n   (cs_n),
    .host_wr_n   (wr_n),
    .host_rd_n   (rd_n),
    .host_bus    (host_bus),
    .play_start  (play_start),
    .play_phrase (play_phrase),
    .play_gain   (play_gain),
    .play_stop   (play_stop),
    .play_done   (play_done)
  );

  // b1, b2, expected start mask, phrase, gain
  localparam logic [32:0] VEC [6] = '{
    {8'h81, 8'h05, 4'b0001, 9'd1,   4'h5},
    {8'hFF, 8'hFF, 4'b1000, 9'd511, 4'hF},
    {8'h80, 8'h40, 4'b0001, 9'd128, 4'h0},
    {8'h80, 8'h00, 4'b0000, 9'd0,   4'h0},
    {8'hAA, 8'h9C, 4'b0010, 9'd298, 4'hC},
    {8'hD5, 8'h23, 4'b0100, 9'd85,  4'h3}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_total++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // called at a falling edge; returns at the falling edge after the accepting rise
  task automatic wr_byte(input logic [7:0] b, input bit sel);
    drv_val = b;
    drv_en  = 1'b1;
    cs_n    = ~sel;
    wr_n    = 1'b0;
    @(negedge clk);
    @(negedge clk);
    wr_n = 1'b1;
    @(negedge clk);
    cs_n   = 1'b1;
    drv_en = 1'b0;
  endtask

  task automatic rd_bus(output logic [7:0] v);
    cs_n = 1'b0;
    rd_n = 1'b0;
    #1;
    v = host_bus;
    rd_n = 1'b1;
    cs_n = 1'b1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_total++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    rst_n = 1'b0; cs_n = 1'b1; wr_n = 1'b1; rd_n = 1'b1;
    drv_en = 1'b0; drv_val = '0; play_done = '0;
    repeat (4) @(negedge clk);
    chk(play_start == 0 && play_stop == 0, "R1 outputs in reset", {play_start, play_stop}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(play_start == 0 && play_stop == 0, "R1 outputs after reset", {play_start, play_stop}, 0);
    rd_bus(v);
    chk(v == 8'h00, "R1 R8 busy after reset", v, 0);

    // table of start commands: R3 R4 R5 R7
    for (int i = 0; i < 6; i++) begin
      logic [32:0] e;
      e = VEC[i];
      wr_byte(e[32:25], 1'b1);
      @(negedge clk);
      chk(play_start == 0, "R4 first byte alone", play_start, 0);
      wr_byte(e[24:17], 1'b1);
      @(negedge clk);
      chk(play_start == e[16:13], "R3 R5 R7 start mask", play_start, e[16:13]);
      if (e[16:13] != 0) begin
        chk(play_phrase == e[12:4], "R3 phrase", play_phrase, e[12:4]);
        chk(play_gain == e[3:0], "R3 gain", play_gain, e[3:0]);
      end
      @(negedge clk);
      chk(play_start == 0, "R3 single-cycle pulse", play_start, 0);
    end

    wr_byte(8'h78, 1'b1);
    @(negedge clk);
    chk(play_stop == 4'hF, "R6 suspend all", play_stop, 4'hF);
    @(negedge clk);
    @(negedge clk);
    rd_bus(v);
    chk(v == 8'h00, "R6 R10 all idle", v, 0);

    // R9 exact delay on channel bit 1
    wr_byte(8'h81, 1'b1);
    wr_byte(8'h11, 1'b1);
    @(negedge clk);
    chk(play_start == 4'b0010, "R9 start ch1", play_start, 4'b0010);
    repeat (34) @(negedge clk);
    rd_bus(v);
    chk(v == 8'h00, "R9 busy one clock early", v, 0);
    @(negedge clk);
    rd_bus(v);
    chk(v == 8'h02, "R9 busy on time", v, 8'h02);

    // R12 restart while busy
    wr_byte(8'h81, 1'b1);
    wr_byte(8'h11, 1'b1);
    @(negedge clk);
    @(negedge clk);
    rd_bus(v);
    chk(v == 8'h02, "R12 busy kept on restart", v, 8'h02);
    repeat (40) @(negedge clk);
    rd_bus(v);
    chk(v == 8'h02, "R12 busy after restart", v, 8'h02);

    // R2 strobe without chip select
    wr_byte(8'h78, 1'b0);
    @(negedge clk);
    chk(play_stop == 0, "R2 no stop without select", play_stop, 0);
    @(negedge clk);
    @(negedge clk);
    rd_bus(v);
    chk(v == 8'h02, "R2 busy unchanged", v, 8'h02);

    // R11 end of playback
    play_done = 4'b0010;
    @(negedge clk);
    play_done = 4'b0000;
    rd_bus(v);
    chk(v == 8'h00, "R11 done clears busy", v, 0);

    // R6 partial mask
    wr_byte(8'h81, 1'b1); wr_byte(8'h00, 1'b1);
    wr_byte(8'h81, 1'b1); wr_byte(8'h20, 1'b1);
    wr_byte(8'h81, 1'b1); wr_byte(8'h30, 1'b1);
    repeat (40) @(negedge clk);
    rd_bus(v);
    chk(v == 8'h0D, "R8 three channels busy", v, 8'h0D);
    wr_byte(8'h28, 1'b1);
    @(negedge clk);
    chk(play_stop == 4'b0101, "R6 stop mask", play_stop, 4'b0101);
    @(negedge clk);
    @(negedge clk);
    rd_bus(v);
    chk(v == 8'h08, "R6 only selected stopped", v, 8'h08);

    // R10 stop arriving on the expiry clock
    wr_byte(8'h81, 1'b1);
    wr_byte(8'h00, 1'b1);
    repeat (31) @(negedge clk);
    wr_byte(8'h08, 1'b1);
    @(negedge clk);
    chk(play_stop == 4'b0001, "R10 stop pulse", play_stop, 4'b0001);
    @(negedge clk);
    rd_bus(v);
    chk(v == 8'h08, "R10 stop wins over expiry", v, 8'h08);
    repeat (5) @(negedge clk);
    rd_bus(v);
    chk(v == 8'h08, "R10 stays idle", v, 8'h08);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end
endmodule